// File: doc/BRIEF.md
# Serial Link Training Sequencer

This block runs the bring-up handshake of one serial lane, working at the level of training ordered sets. The receive side arrives already decoded. Each received set is presented for one cycle with its kind (first or second training set) and with its link and lane fields, each of which is either a value or the padding marker. The transmit side is driven by a serializer that pulses `txDone` once for every set it has sent. The sequencer tells that serializer which kind of set to send next and which link and lane values to place in it.

The handshake runs through seven phases. First the block waits for a far-end receiver. It then sends first-kind sets until it has heard one from the partner, and sends a fixed number more after that. Next it sends second-kind sets until it has heard enough of them in a row, and sends a fixed number more. After that it adopts the partner's link number, then the lane number, sends a closing burst, and reports link-up. Every phase that waits on the partner is bounded by a cycle timeout that sends the block back to detection. A synchronous reset does the same.

Top module: `link_train_seq`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) `phase` is 0 (detect), `txActive` and `linkUp` are 0, and both transmit fields show padding. The block stays in phase 0 for as long as `rxPresent` is low. Phase codes are: 0 detect, 1 first-kind polling, 2 second-kind polling, 3 link negotiation, 4 lane negotiation, 5 closing burst, 6 link up.
- R2: In phase 0, a cycle with `rxPresent` high moves the block to phase 1 at the next edge. In phase 1 it transmits first-kind sets (`txActive`=1, `txIsTs2`=0) with both fields padded.
- R3: In phase 1, `txDone` pulses are not counted until one first-kind set has been received. A received second-kind set has no effect. After that first-kind set, exactly POLL_TX_COUNT (1024) counted pulses move the block to phase 2 on the edge that takes the last pulse.
- R4: In phase 2 the block transmits second-kind sets (`txIsTs2`=1) with padded fields. It needs TS2_RX_COUNT (8) consecutive received second-kind sets. Any other received set resets that run to zero.
- R5: In phase 2, `txDone` pulses seen before the run completes are ignored. After the run completes, exactly TS2_TX_COUNT (16) pulses move the block to phase 3.
- R6: In phase 3 the block transmits first-kind sets with both fields padded. It needs CFG_RX_COUNT (2) consecutive first-kind sets whose link field is not padding. A second-kind set or a padded link field breaks the run. The link value is taken from the first set of the completing run.
- R7: In phase 4 the block transmits the adopted link value with the lane field padded. It needs CFG_RX_COUNT consecutive first-kind sets with both link and lane not padded. The lane value comes from the first set of the completing run, and the block then moves to phase 5.
- R8: In phase 5 the block transmits both adopted values. After DONE_TX_COUNT (8) `txDone` pulses it enters phase 6, where `linkUp` is 1. It stays there until reset, and the transmitted fields stay unpadded.
- R9: In phases 1 to 5, if the block has not advanced TIMEOUT_CYCLES cycles after entering the phase, it returns to phase 0 with its fields padded. It is in the phase for exactly TIMEOUT_CYCLES cycles.
- R10: Reset part-way through training clears every count and the "partner heard" condition, so a second training run needs the full counts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxPresent | input | 1 | Far-end receiver detected |
| rxValid | input | 1 | A decoded received set is present this cycle |
| rxIsTs2 | input | 1 | Received set kind: 1 second-kind, 0 first-kind |
| rxLinkPad | input | 1 | Received link field is padding |
| rxLink | input | LINK_W | Received link number |
| rxLanePad | input | 1 | Received lane field is padding |
| rxLane | input | LANE_W | Received lane number |
| txDone | input | 1 | One-cycle pulse: one set has been transmitted |
| txActive | output | 1 | Transmitter should send training sets |
| txIsTs2 | output | 1 | Kind of set to send: 1 second-kind, 0 first-kind |
| txLinkPad | output | 1 | Transmit link field as padding |
| txLink | output | LINK_W | Link number to transmit (zero when padded) |
| txLanePad | output | 1 | Transmit lane field as padding |
| txLane | output | LANE_W | Lane number to transmit (zero when padded) |
| linkUp | output | 1 | Training complete |
| phase | output | 3 | Current handshake phase code |

## Verification
The bench keeps every count at its default: 1024, 8, 16, 2 and 8. This means the exact 1024th counted pulse and the 8th consecutive second-kind set are both checked at their true boundaries. The only change is TIMEOUT_CYCLES, which drops to 4000. At that value the timeout can be reached and measured to the cycle, and it still leaves enough room for a full 1024-pulse polling phase, plus the pulses the bench sends to show they are ignored, to finish well before it. Randomized negotiation streams mix padded, second-kind and valid sets, so the run-reset and value-latching rules are exercised against a bench model.

// File: rtl/lts_pkg.sv
package lts_pkg;

  typedef enum logic [2:0] {
    PH_DETECT   = 3'd0,
    PH_POLL_TS1 = 3'd1,
    PH_POLL_TS2 = 3'd2,
    PH_CFG_LINK = 3'd3,
    PH_CFG_LANE = 3'd4,
    PH_CFG_DONE = 3'd5,
    PH_LINK_UP  = 3'd6
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic phaseClr;   // new phase: clear counters, flag, timer
    logic fieldClr;   // back to detect: forget adopted numbers
    logic txInc;
    logic rxInc;
    logic rxClr;
    logic setMet;     // receive condition of this phase satisfied
    logic latchLink;
    logic latchLane;
  } dpCtl_t;

endpackage

// File: rtl/lts_field.sv
module lts_field #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (load)  q <= d;
  end

endmodule

// File: rtl/lts_dp.sv
module lts_dp
  import lts_pkg::*;
#(
  parameter int CNT_W          = 11,
  parameter int RX_W           = 4,
  parameter int TIMEOUT_CYCLES = 65536,
  parameter int LINK_W         = 8,
  parameter int LANE_W         = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            ctl,
  input  logic [LINK_W-1:0] rxLink,
  input  logic [LANE_W-1:0] rxLane,
  output logic [CNT_W-1:0]  txCnt,
  output logic [RX_W-1:0]   rxCnt,
  output logic              met,
  output logic              timerLast,
  output logic [LINK_W-1:0] linkVal,
  output logic [LANE_W-1:0] laneVal
);

  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYCLES - 1);

  logic [TMR_W-1:0] timer;

  always_ff @(posedge clk) begin
    if (rst || ctl.phaseClr) begin
      txCnt <= '0;
      rxCnt <= '0;
      met   <= 1'b0;
      timer <= '0;
    end else begin
      if (ctl.txInc) txCnt <= txCnt + 1'b1;
      if (ctl.rxClr)      rxCnt <= '0;
      else if (ctl.rxInc) rxCnt <= rxCnt + 1'b1;
      if (ctl.setMet) met <= 1'b1;
      if (timer != TMR_LAST) timer <= timer + 1'b1;
    end
  end

  assign timerLast = (timer == TMR_LAST);

  localparam int NFIELD = 2;
  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    if (g == 0) begin : g_link
      lts_field #(.W(LINK_W)) u_fld (
        .clk(clk), .rst(rst), .clr(ctl.fieldClr),
        .load(ctl.latchLink), .d(rxLink), .q(linkVal)
      );
    end else begin : g_lane
      lts_field #(.W(LANE_W)) u_fld (
        .clk(clk), .rst(rst), .clr(ctl.fieldClr),
        .load(ctl.latchLane), .d(rxLane), .q(laneVal)
      );
    end
  end

endmodule

// File: rtl/lts_ctrl.sv
module lts_ctrl
  import lts_pkg::*;
#(
  parameter int POLL_TX_COUNT = 1024,
  parameter int TS2_RX_COUNT  = 8,
  parameter int TS2_TX_COUNT  = 16,
  parameter int CFG_RX_COUNT  = 2,
  parameter int DONE_TX_COUNT = 8,
  parameter int CNT_W         = 11,
  parameter int RX_W          = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxPresent,
  input  logic             rxValid,
  input  logic             rxIsTs2,
  input  logic             rxLinkPad,
  input  logic             rxLanePad,
  input  logic             txDone,
  input  logic [CNT_W-1:0] txCnt,
  input  logic [RX_W-1:0]  rxCnt,
  input  logic             met,
  input  logic             timerLast,
  output phase_e           phaseQ,
  output dpCtl_t           ctl
);

  localparam logic [CNT_W-1:0] POLL_LAST = CNT_W'(POLL_TX_COUNT - 1);
  localparam logic [CNT_W-1:0] TS2_LAST  = CNT_W'(TS2_TX_COUNT - 1);
  localparam logic [CNT_W-1:0] DONE_LAST = CNT_W'(DONE_TX_COUNT - 1);
  localparam logic [RX_W-1:0]  TS2_RLAST = RX_W'(TS2_RX_COUNT - 1);
  localparam logic [RX_W-1:0]  CFG_RLAST = RX_W'(CFG_RX_COUNT - 1);

  phase_e nxt;
  logic   qual;
  logic   waiting;

  // which received sets count toward the current phase
  always_comb begin
    unique case (phaseQ)
      PH_POLL_TS1: qual = rxValid && !rxIsTs2;
      PH_POLL_TS2: qual = rxValid && rxIsTs2;
      PH_CFG_LINK: qual = rxValid && !rxIsTs2 && !rxLinkPad;
      PH_CFG_LANE: qual = rxValid && !rxIsTs2 && !rxLinkPad && !rxLanePad;
      default:     qual = 1'b0;
    endcase
  end

  assign waiting = (phaseQ != PH_DETECT) && (phaseQ != PH_LINK_UP);

  always_comb begin
    nxt = phaseQ;
    ctl = '0;
    unique case (phaseQ)
      PH_DETECT: begin
        if (rxPresent) nxt = PH_POLL_TS1;
      end
      PH_POLL_TS1: begin
        if (qual) ctl.setMet = 1'b1;
        if (txDone && met) begin
          ctl.txInc = 1'b1;
          if (txCnt == POLL_LAST) nxt = PH_POLL_TS2;
        end
      end
      PH_POLL_TS2: begin
        if (!met) begin
          if (qual) begin
            if (rxCnt == TS2_RLAST) ctl.setMet = 1'b1;
            else                    ctl.rxInc  = 1'b1;
          end else if (rxValid) begin
            ctl.rxClr = 1'b1;
          end
        end else if (txDone) begin
          ctl.txInc = 1'b1;
          if (txCnt == TS2_LAST) nxt = PH_CFG_LINK;
        end
      end
      PH_CFG_LINK: begin
        if (qual) begin
          if (rxCnt == '0) ctl.latchLink = 1'b1;
          if (rxCnt == CFG_RLAST) nxt = PH_CFG_LANE;
          else                    ctl.rxInc = 1'b1;
        end else if (rxValid) begin
          ctl.rxClr = 1'b1;
        end
      end
      PH_CFG_LANE: begin
        if (qual) begin
          if (rxCnt == '0) ctl.latchLane = 1'b1;
          if (rxCnt == CFG_RLAST) nxt = PH_CFG_DONE;
          else                    ctl.rxInc = 1'b1;
        end else if (rxValid) begin
          ctl.rxClr = 1'b1;
        end
      end
      PH_CFG_DONE: begin
        if (txDone) begin
          ctl.txInc = 1'b1;
          if (txCnt == DONE_LAST) nxt = PH_LINK_UP;
        end
      end
      default: nxt = phaseQ;
    endcase

    // progress in the same cycle wins over the timeout
    if (waiting && timerLast && nxt == phaseQ) nxt = PH_DETECT;

    if (nxt != phaseQ) ctl.phaseClr = 1'b1;
    if (nxt == PH_DETECT && phaseQ != PH_DETECT) ctl.fieldClr = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) phaseQ <= PH_DETECT;
    else     phaseQ <= nxt;
  end

endmodule

// File: rtl/link_train_seq.sv
module link_train_seq
  import lts_pkg::*;
#(
  parameter int POLL_TX_COUNT  = 1024,
  parameter int TS2_RX_COUNT   = 8,
  parameter int TS2_TX_COUNT   = 16,
  parameter int CFG_RX_COUNT   = 2,
  parameter int DONE_TX_COUNT  = 8,
  parameter int TIMEOUT_CYCLES = 65536,
  parameter int LINK_W         = 8,
  parameter int LANE_W         = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxPresent,
  input  logic              rxValid,
  input  logic              rxIsTs2,
  input  logic              rxLinkPad,
  input  logic [LINK_W-1:0] rxLink,
  input  logic              rxLanePad,
  input  logic [LANE_W-1:0] rxLane,
  input  logic              txDone,
  output logic              txActive,
  output logic              txIsTs2,
  output logic              txLinkPad,
  output logic [LINK_W-1:0] txLink,
  output logic              txLanePad,
  output logic [LANE_W-1:0] txLane,
  output logic              linkUp,
  output logic [2:0]        phase
);

  localparam int TX_MAX_A = (POLL_TX_COUNT > TS2_TX_COUNT) ? POLL_TX_COUNT : TS2_TX_COUNT;
  localparam int TX_MAX   = (TX_MAX_A > DONE_TX_COUNT) ? TX_MAX_A : DONE_TX_COUNT;
  localparam int RX_MAX   = (TS2_RX_COUNT > CFG_RX_COUNT) ? TS2_RX_COUNT : CFG_RX_COUNT;
  localparam int CNT_W    = $clog2(TX_MAX + 1);
  localparam int RX_W     = $clog2(RX_MAX + 1);

  phase_e            phaseQ;
  dpCtl_t            ctl;
  logic [CNT_W-1:0]  txCnt;
  logic [RX_W-1:0]   rxCnt;
  logic              met;
  logic              timerLast;
  logic [LINK_W-1:0] linkVal;
  logic [LANE_W-1:0] laneVal;
  logic              showLink;
  logic              showLane;

  lts_ctrl #(
    .POLL_TX_COUNT(POLL_TX_COUNT), .TS2_RX_COUNT(TS2_RX_COUNT),
    .TS2_TX_COUNT(TS2_TX_COUNT), .CFG_RX_COUNT(CFG_RX_COUNT),
    .DONE_TX_COUNT(DONE_TX_COUNT), .CNT_W(CNT_W), .RX_W(RX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .rxPresent(rxPresent), .rxValid(rxValid),
    .rxIsTs2(rxIsTs2), .rxLinkPad(rxLinkPad), .rxLanePad(rxLanePad),
    .txDone(txDone), .txCnt(txCnt), .rxCnt(rxCnt), .met(met),
    .timerLast(timerLast), .phaseQ(phaseQ), .ctl(ctl)
  );

  lts_dp #(
    .CNT_W(CNT_W), .RX_W(RX_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .LINK_W(LINK_W), .LANE_W(LANE_W)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .rxLink(rxLink), .rxLane(rxLane),
    .txCnt(txCnt), .rxCnt(rxCnt), .met(met), .timerLast(timerLast),
    .linkVal(linkVal), .laneVal(laneVal)
  );

  assign showLink  = (phaseQ == PH_CFG_LANE) || (phaseQ == PH_CFG_DONE) || (phaseQ == PH_LINK_UP);
  assign showLane  = (phaseQ == PH_CFG_DONE) || (phaseQ == PH_LINK_UP);
  assign txActive  = (phaseQ != PH_DETECT);
  assign txIsTs2   = (phaseQ == PH_POLL_TS2);
  assign txLinkPad = !showLink;
  assign txLanePad = !showLane;
  assign txLink    = showLink ? linkVal : '0;
  assign txLane    = showLane ? laneVal : '0;
  assign linkUp    = (phaseQ == PH_LINK_UP);
  assign phase     = phaseQ;

endmodule

// File: rtl/lts_chk.sv
module lts_chk #(
  parameter int TIMEOUT_CYCLES = 65536,
  parameter int LINK_W         = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rxPresent,
  input logic [2:0]        phase,
  input logic              txIsTs2,
  input logic              txLinkPad,
  input logic              txLanePad,
  input logic [LINK_W-1:0] txLink,
  input logic              linkUp
);

  logic [31:0] dwell;
  logic [2:0]  prevPh;
  logic        waiting;

  always_ff @(posedge clk) begin
    if (rst) begin
      dwell  <= '0;
      prevPh <= '0;
    end else begin
      prevPh <= phase;
      dwell  <= (phase == prevPh) ? dwell + 1 : '0;
    end
  end

  assign waiting = (phase != 3'd0) && (phase != 3'd6);

  // R1
  detect_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd0 && !rxPresent) |=> phase == 3'd0);

  // R2
  detect_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd0 && rxPresent) |=> phase == 3'd1);

  // R3
  poll_exit_chk: assert property (@(posedge clk) disable iff (rst)
    phase == 3'd1 |=> (phase == 3'd1 || phase == 3'd2 || phase == 3'd0));

  // R4
  ts2_pad_chk: assert property (@(posedge clk) disable iff (rst)
    txIsTs2 |-> (txLinkPad && txLanePad));

  // R7
  link_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !txLinkPad |=> (txLinkPad || $stable(txLink)));

  // R8
  linkup_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    linkUp |=> linkUp);

  // R8
  linkup_fields_chk: assert property (@(posedge clk) disable iff (rst)
    linkUp |-> (!txLinkPad && !txLanePad));

  // R9
  timeout_window_chk: assert property (@(posedge clk) disable iff (rst)
    waiting |-> dwell < 32'(TIMEOUT_CYCLES));

endmodule

bind link_train_seq lts_chk #(
  .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .LINK_W(LINK_W)
) u_chk (
  .clk(clk), .rst(rst), .rxPresent(rxPresent), .phase(phase),
  .txIsTs2(txIsTs2), .txLinkPad(txLinkPad), .txLanePad(txLanePad),
  .txLink(txLink), .linkUp(linkUp)
);

// File: tb/link_train_seq_bench.sv
module link_train_seq_bench;

  localparam int LINK_W  = 8;
  localparam int LANE_W  = 5;
  localparam int TMO     = 4000;
  localparam int POLL_N  = 1024;
  localparam int TS2RX_N = 8;
  localparam int TS2TX_N = 16;
  localparam int DONE_N  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxPresent = 1'b0, rxValid = 1'b0, rxIsTs2 = 1'b0;
  logic rxLinkPad = 1'b1, rxLanePad = 1'b1, txDone = 1'b0;
  logic [LINK_W-1:0] rxLink = '0;
  logic [LANE_W-1:0] rxLane = '0;
  logic txActive, txIsTs2, txLinkPad, txLanePad, linkUp;
  logic [LINK_W-1:0] txLink;
  logic [LANE_W-1:0] txLane;
  logic [2:0] phase;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;   // 50 MHz

  link_train_seq #(.TIMEOUT_CYCLES(TMO), .LINK_W(LINK_W), .LANE_W(LANE_W)) u_link_train_seq (
    .clk(clk), .rst(rst), .rxPresent(rxPresent), .rxValid(rxValid),
    .rxIsTs2(rxIsTs2), .rxLinkPad(rxLinkPad), .rxLink(rxLink),
    .rxLanePad(rxLanePad), .rxLane(rxLane), .txDone(txDone),
    .txActive(txActive), .txIsTs2(txIsTs2), .txLinkPad(txLinkPad),
    .txLink(txLink), .txLanePad(txLanePad), .txLane(txLane),
    .linkUp(linkUp), .phase(phase)
  );

  function automatic bit linkQual(bit ts2, bit lpad);
    return !ts2 && !lpad;
  endfunction

  function automatic bit laneQual(bit ts2, bit lpad, bit npad);
    return !ts2 && !lpad && !npad;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseTx(input int n);
    for (int i = 0; i < n; i++) begin
      txDone = 1'b1;
      @(negedge clk);
    end
    txDone = 1'b0;
  endtask

  task automatic sendRx(input bit ts2, input bit lpad, input logic [LINK_W-1:0] lk,
                        input bit npad, input logic [LANE_W-1:0] ln);
    rxValid = 1'b1; rxIsTs2 = ts2; rxLinkPad = lpad; rxLink = lk;
    rxLanePad = npad; rxLane = ln;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  task automatic enterPoll();
    rxPresent = 1'b1;
    @(negedge clk);
    rxPresent = 1'b0;
  endtask

  // random walk through link then lane negotiation against the bench model
  task automatic randomCfg(output logic [LINK_W-1:0] expLink, output logic [LANE_W-1:0] expLane);
    int cnt;
    bit ts2, lp, np, q;
    logic [LINK_W-1:0] lk;
    logic [LANE_W-1:0] ln;
    cnt = 0;
    expLink = '0;
    for (int i = 0; i < 30 && cnt < 2; i++) begin
      ts2 = ($urandom % 4) == 0; lp = ($urandom % 3) == 0;
      lk = LINK_W'($urandom); ln = LANE_W'($urandom);
      q = linkQual(ts2, lp);
      if (q) begin if (cnt == 0) expLink = lk; cnt++; end else cnt = 0;
      sendRx(ts2, lp, lk, 1'b1, ln);
      if (cnt < 2) check("R6 random link run", phase, 3);
    end
    while (cnt < 2) begin
      lk = LINK_W'($urandom);
      if (cnt == 0) expLink = lk;
      cnt++;
      sendRx(1'b0, 1'b0, lk, 1'b1, '0);
    end
    check("R6 link phase exit", phase, 4);
    check("R7 adopted link", txLink, expLink);
    cnt = 0;
    expLane = '0;
    for (int i = 0; i < 30 && cnt < 2; i++) begin
      ts2 = ($urandom % 4) == 0; lp = ($urandom % 5) == 0; np = ($urandom % 3) == 0;
      lk = LINK_W'($urandom); ln = LANE_W'($urandom);
      q = laneQual(ts2, lp, np);
      if (q) begin if (cnt == 0) expLane = ln; cnt++; end else cnt = 0;
      sendRx(ts2, lp, lk, np, ln);
      if (cnt < 2) check("R7 random lane run", phase, 4);
    end
    while (cnt < 2) begin
      ln = LANE_W'($urandom);
      if (cnt == 0) expLane = ln;
      cnt++;
      sendRx(1'b0, 1'b0, 8'd1, 1'b0, ln);
    end
    check("R7 lane phase exit", phase, 5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [LINK_W-1:0] eLink;
    logic [LANE_W-1:0] eLane;
    int seedv;
    seedv = $urandom(32'h5eed1);
    idle(3);
    rst = 1'b0;
    check("R1 reset phase", phase, 0);
    check("R1 reset txActive", txActive, 0);
    check("R1 reset linkUp", linkUp, 0);
    check("R1 reset link pad", txLinkPad, 1);
    idle(6);
    check("R1 detect hold", phase, 0);

    enterPoll();
    check("R2 detect exit", phase, 1);
    check("R2 tx kind", txIsTs2, 0);
    check("R2 txActive", txActive, 1);
    check("R2 lane pad", txLanePad, 1);

    // R3: early pulses and a second-kind set are ignored
    pulseTx(5);
    sendRx(1'b1, 1'b1, '0, 1'b1, '0);
    pulseTx(POLL_N);
    check("R3 uncounted before heard", phase, 1);
    sendRx(1'b0, 1'b1, '0, 1'b1, '0);
    pulseTx(POLL_N - 1);
    check("R3 one short", phase, 1);
    pulseTx(1);
    check("R3 exact count", phase, 2);

    // R4 / R5
    check("R4 tx second kind", txIsTs2, 1);
    for (int i = 0; i < 5; i++) sendRx(1'b1, 1'b1, '0, 1'b1, '0);
    sendRx(1'b0, 1'b1, '0, 1'b1, '0);
    for (int i = 0; i < TS2RX_N - 1; i++) sendRx(1'b1, 1'b1, '0, 1'b1, '0);
    pulseTx(TS2TX_N + 4);
    check("R4 run reset by other set", phase, 2);
    check("R5 pulses before run ignored", phase, 2);
    sendRx(1'b1, 1'b1, '0, 1'b1, '0);
    pulseTx(TS2TX_N - 1);
    check("R5 one short", phase, 2);
    pulseTx(1);
    check("R5 exact count", phase, 3);

    // R6 directed
    check("R6 link pad", txLinkPad, 1);
    check("R6 tx kind", txIsTs2, 0);
    sendRx(1'b0, 1'b0, 8'd11, 1'b1, '0);
    sendRx(1'b1, 1'b0, 8'd12, 1'b1, '0);
    sendRx(1'b0, 1'b1, 8'd13, 1'b1, '0);
    sendRx(1'b0, 1'b0, 8'd42, 1'b1, '0);
    check("R6 run not complete", phase, 3);
    sendRx(1'b0, 1'b0, 8'd77, 1'b1, '0);
    check("R6 advance", phase, 4);
    check("R7 link from first of run", txLink, 42);
    check("R7 lane pad", txLanePad, 1);

    // R7 directed
    sendRx(1'b0, 1'b0, 8'd42, 1'b1, 5'd3);
    sendRx(1'b0, 1'b0, 8'd42, 1'b0, 5'd9);
    sendRx(1'b0, 1'b0, 8'd42, 1'b0, 5'd20);
    check("R7 advance", phase, 5);
    check("R7 lane from first of run", txLane, 9);
    check("R8 lane shown", txLanePad, 0);

    // R8
    pulseTx(DONE_N - 1);
    check("R8 one short", linkUp, 0);
    pulseTx(1);
    check("R8 link up", linkUp, 1);
    check("R8 phase", phase, 6);
    rxPresent = 1'b0;
    sendRx(1'b1, 1'b1, '0, 1'b1, '0);
    idle(TMO + 10);
    check("R8 link up held", linkUp, 1);
    check("R8 link kept", txLink, 42);

    // R10: reset mid-polling clears heard flag and count
    doReset();
    check("R10 reset phase", phase, 0);
    check("R10 reset fields", txLinkPad, 1);
    enterPoll();
    sendRx(1'b0, 1'b1, '0, 1'b1, '0);
    pulseTx(600);
    doReset();
    check("R10 reset again", phase, 0);
    enterPoll();
    pulseTx(POLL_N + 50);
    check("R10 heard flag cleared", phase, 1);
    sendRx(1'b0, 1'b1, '0, 1'b1, '0);
    pulseTx(POLL_N - 1);
    check("R10 count cleared", phase, 1);
    pulseTx(1);
    check("R10 full count then advance", phase, 2);

    // R9: timeout in second-kind polling
    idle(TMO - 1);
    check("R9 before timeout", phase, 2);
    idle(1);
    check("R9 timeout to detect", phase, 0);
    check("R9 fields padded", txLinkPad, 1);

    // random trainings
    for (int run = 0; run < 3; run++) begin
      doReset();
      enterPoll();
      for (int k = 0; k < int'($urandom % 4); k++) sendRx(1'b1, 1'b1, '0, 1'b1, '0);
      pulseTx(int'($urandom % 20));
      sendRx(1'b0, 1'b1, '0, 1'b1, '0);
      pulseTx(POLL_N);
      check("R3 random poll", phase, 2);
      for (int k = 0; k < int'($urandom % 4); k++) sendRx(1'b0, 1'b1, '0, 1'b1, '0);
      for (int k = 0; k < TS2RX_N; k++) sendRx(1'b1, 1'b1, '0, 1'b1, '0);
      pulseTx(TS2TX_N);
      check("R5 random ts2", phase, 3);
      randomCfg(eLink, eLane);
      pulseTx(DONE_N);
      check("R8 random link up", linkUp, 1);
      check("R8 random link", txLink, eLink);
      check("R8 random lane", txLane, eLane);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule